// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter driven by two independent count strobes: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. The parameter `DECADE` picks the sequence. With `DECADE=1` the counter runs 0 to 9 in 8421 BCD. With `DECADE=0` it runs modulo 16. Two active-low terminal flags, `carry_n` and `borrow_n`, fall while the counter sits at its top or bottom value and the matching strobe is low. Each flag rises again at the same moment the counter wraps, so a flag can serve as the up or down strobe of the next stage and a chain of stages needs no glue logic.

Two overrides take precedence over counting. `clear` forces the value to zero. `load_n` held low makes the value follow `preset`. When both are active, `clear` wins. The strobes and the overrides are not tied to the system clock `clk`. Each of them passes through a two-flop synchronizer, and counting acts on rising edges that are detected in the `clk` domain. The `preset` bus must be held stable while `load_n` is low.

Top module: `ud_dual_clk_counter`

## Requirements
- R1: During and after synchronous reset `rst`, `count` is 0 and `carry_n` is 1.
- R2: A single rising edge on `cnt_up` adds exactly one to `count`, and its falling edge changes nothing. The new value appears after the third `clk` edge that follows the input change.
- R3: A single rising edge on `cnt_dn` subtracts exactly one from `count`.
- R4: With `DECADE=1`, counting up from 9 gives 0 and counting down from 0 gives 9.
- R5: With `DECADE=0`, counting up from 15 gives 0 and counting down from 0 gives 15.
- R6: When `cnt_up` and `cnt_dn` rise in the same `clk` sample, `count` does not change.
- R7: While `load_n` is 0, `count` equals `preset` and both strobes are ignored. After `load_n` returns to 1, the loaded value is kept.
- R8: While `clear` is 1, `count` is 0, even if `load_n` is 0 at the same time.
- R9: `carry_n` is 0 exactly when the synchronized `cnt_up` is 0 and `count` equals the maximum (9 in decade mode, 15 in binary mode). It is 1 while `cnt_up` is high.
- R10: `borrow_n` is 0 exactly when the synchronized `cnt_dn` is 0 and `count` is 0.
- R11: With `DECADE=1`, a loaded value from 10 to 15 recovers as follows. An up count from 10 to 14 adds one. An up count from 15 gives 0. A down count from any of 10 to 15 subtracts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | Up count strobe; acts on its rising edge |
| cnt_dn | input | 1 | Down count strobe; acts on its rising edge |
| load_n | input | 1 | Active-low preset load; overrides counting |
| clear | input | 1 | Active-high clear to zero; overrides load and counting |
| preset | input | WIDTH | Value copied in while loading |
| count | output | WIDTH | Counter value |
| carry_n | output | 1 | Active-low terminal flag at the maximum, for cascading up |
| borrow_n | output | 1 | Active-low terminal flag at zero, for cascading down |

## Verification
The hardest states to reach from the ports are the decade-mode values from 10 to 15. Counting never produces them, so the only way in is a preset load, and each one then has to be left with a single up or down strobe. The bench reaches them with directed loads of 12, 15 and 11. It also mixes preset loads of arbitrary four-bit values into a long random sequence of single, simultaneous and overridden strobes. Checking the terminal flags while the up strobe is still held high at the wrap point needs a mid-pulse sample, and the bench takes that sample on every up pulse.

// File: rtl/ud_pkg.sv
package ud_pkg;
  typedef enum logic [1:0] {STEP_HOLD, STEP_UP, STEP_DOWN} step_e;

  // Largest value in the counting sequence.
  function automatic int unsigned seq_max(bit decade, int unsigned width);
    return decade ? 9 : ((1 << width) - 1);
  endfunction
endpackage

// File: rtl/ud_sync2.sv
module ud_sync2 #(
  parameter int unsigned LANES  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d_async,
  output logic [LANES-1:0] q_sync
);
  logic [LANES-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ud_count_core.sv
module ud_count_core
  import ud_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] preset_s,
  output logic [WIDTH-1:0] cnt_nxt,
  output logic [WIDTH-1:0] cnt_q
);
  localparam logic [WIDTH-1:0] CMAX = WIDTH'(seq_max(DECADE, WIDTH));
  localparam logic [WIDTH-1:0] CTOP = '1;

  logic  up_prev, dn_prev;
  logic  up_rise, dn_rise;
  step_e step;

  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;

  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise) step = STEP_UP;
    else if (dn_rise && !up_rise) step = STEP_DOWN;
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr) cnt_nxt = '0;
    else if (ld) cnt_nxt = preset_s;
    else begin
      case (step)
        STEP_UP:   cnt_nxt = (cnt_q == CMAX || cnt_q == CTOP) ? '0 : cnt_q + 1'b1;
        STEP_DOWN: cnt_nxt = (cnt_q == '0) ? CMAX : cnt_q - 1'b1;
        default:   cnt_nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      up_prev <= 1'b0;
      dn_prev <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> cnt_q == '0);
  // R7
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ld && !clr) |-> cnt_q == $past(preset_s));
  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(up_rise && dn_rise && !clr && !ld) |-> $stable(cnt_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!up_rise && !dn_rise && !clr && !ld) |-> $stable(cnt_q));
endmodule

// File: rtl/ud_term_flags.sv
module ud_term_flags
  import ud_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic [WIDTH-1:0] cnt_q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] CMAX = WIDTH'(seq_max(DECADE, WIDTH));

  // The flags are registered alongside the count, so both change on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= ~(~up_lvl && (cnt_nxt == CMAX));
      borrow_n <= ~(~dn_lvl && (cnt_nxt == '0));
    end
  end

  // R9
  carry_max_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> cnt_q == CMAX);
  // R10
  borrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> cnt_q == '0);
  // R9
  carry_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(up_lvl) |-> carry_n);
endmodule

// File: rtl/ud_dual_clk_counter.sv
module ud_dual_clk_counter #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int unsigned CTRL_LANES = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  logic [CTRL_LANES-1:0] ctrl_raw, ctrl_s;
  logic [WIDTH-1:0]      preset_s, cnt_nxt, cnt_q;

  assign ctrl_raw = {~load_n, clear, cnt_dn, cnt_up};

  ud_sync2 #(.LANES(CTRL_LANES), .STAGES(SYNC_DEPTH)) u_ctrl_sync (
    .clk(clk), .rst(rst), .d_async(ctrl_raw), .q_sync(ctrl_s));

  ud_sync2 #(.LANES(WIDTH), .STAGES(SYNC_DEPTH)) u_preset_sync (
    .clk(clk), .rst(rst), .d_async(preset), .q_sync(preset_s));

  ud_count_core #(.WIDTH(WIDTH), .DECADE(DECADE)) u_core (
    .clk(clk), .rst(rst),
    .up_lvl(ctrl_s[0]), .dn_lvl(ctrl_s[1]),
    .clr(ctrl_s[2]), .ld(ctrl_s[3]),
    .preset_s(preset_s), .cnt_nxt(cnt_nxt), .cnt_q(cnt_q));

  ud_term_flags #(.WIDTH(WIDTH), .DECADE(DECADE)) u_flags (
    .clk(clk), .rst(rst),
    .up_lvl(ctrl_s[0]), .dn_lvl(ctrl_s[1]),
    .cnt_nxt(cnt_nxt), .cnt_q(cnt_q),
    .carry_n(carry_n), .borrow_n(borrow_n));

  assign count = cnt_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && carry_n));
endmodule

// File: tb/ud_dual_clk_counter_tb.sv
module ud_dual_clk_counter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_up = 1'b0, cnt_dn = 1'b0, load_n = 1'b1, clear = 1'b0;
  logic [3:0] preset = '0;
  logic [3:0] cnt_d, cnt_b;
  logic       cy_d, bw_d, cy_b, bw_b;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned md = 0, mb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ud_dual_clk_counter #(.WIDTH(4), .DECADE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .load_n(load_n),
    .clear(clear), .preset(preset), .count(cnt_d), .carry_n(cy_d), .borrow_n(bw_d));

  ud_dual_clk_counter #(.WIDTH(4), .DECADE(1'b0)) u_dut_bin (
    .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .load_n(load_n),
    .clear(clear), .preset(preset), .count(cnt_b), .carry_n(cy_b), .borrow_n(bw_b));

  function automatic int unsigned nx_up(int unsigned v, bit dec);
    if (dec) return (v == 9 || v == 15) ? 0 : v + 1;
    return (v + 1) % 16;
  endfunction

  function automatic int unsigned nx_dn(int unsigned v, bit dec);
    if (v == 0) return dec ? 9 : 15;
    return v - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk({req, " dec count"}, cnt_d, md);
    chk({req, " bin count"}, cnt_b, mb);
    chk("R9 dec carry", cy_d, (md == 9) ? 0 : 1);
    chk("R9 bin carry", cy_b, (mb == 15) ? 0 : 1);
    chk("R10 dec borrow", bw_d, (md == 0) ? 0 : 1);
    chk("R10 bin borrow", bw_b, (mb == 0) ? 0 : 1);
  endtask

  task automatic pulse(bit up, bit dn, string req);
    cnt_up = up; cnt_dn = dn;
    settle();
    if (up && !dn) begin
      md = nx_up(md, 1); mb = nx_up(mb, 0);
    end else if (dn && !up) begin
      md = nx_dn(md, 1); mb = nx_dn(mb, 0);
    end
    chk({req, " mid dec count"}, cnt_d, md);
    if (up) begin
      chk("R9 carry high while up high dec", cy_d, 1);
      chk("R9 carry high while up high bin", cy_b, 1);
    end
    cnt_up = 0; cnt_dn = 0;
    settle();
    check_all(req);
  endtask

  task automatic do_load(int unsigned v);
    preset = 4'(v); load_n = 0;
    settle();
    md = v; mb = v;
    chk("R7 load dec", cnt_d, v);
    chk("R7 load bin", cnt_b, v);
    cnt_up = 1; settle(); cnt_dn = 1; cnt_up = 0; settle(); cnt_dn = 0; settle();
    chk("R7 strobes ignored dec", cnt_d, v);
    chk("R7 strobes ignored bin", cnt_b, v);
    load_n = 1;
    preset = 4'(v + 3);
    settle();
    check_all("R7 kept after release");
  endtask

  task automatic do_clear(bit with_load);
    clear = 1;
    if (with_load) begin preset = 4'd5; load_n = 0; end
    settle();
    md = 0; mb = 0;
    chk("R8 clear dec", cnt_d, 0);
    chk("R8 clear bin", cnt_b, 0);
    clear = 0; load_n = 1;
    settle();
    check_all("R8 after clear");
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset dec count", cnt_d, 0);
    chk("R1 reset carry", cy_d, 1);
    rst = 0;
    settle();
    check_all("R1 after reset");

    // R2 and R4: full decade run, one extra step wraps
    for (int i = 0; i < 10; i++) pulse(1, 0, "R2 R4 up");
    chk("R4 dec wrapped to 0", cnt_d, 0);
    pulse(0, 1, "R3 R4 R5 down from 0");
    chk("R4 dec 0 down gives 9", cnt_d, 9);
    chk("R5 bin 0 up*10 down", cnt_b, 9);
    do_load(15);
    pulse(1, 0, "R5 R11 up from 15");
    chk("R5 bin 15 up gives 0", cnt_b, 0);
    chk("R11 dec 15 up gives 0", cnt_d, 0);
    do_load(12);
    pulse(1, 0, "R11 up from 12");
    chk("R11 dec 12 up gives 13", cnt_d, 13);
    do_load(11);
    pulse(0, 1, "R11 down from 11");
    chk("R11 dec 11 down gives 10", cnt_d, 10);
    pulse(1, 1, "R6 both");
    chk("R6 both hold", cnt_d, 10);
    do_clear(1);
    do_clear(0);

    for (int n = 0; n < 200; n++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 4) pulse(1, 0, "R2 random up");
      else if (op < 7) pulse(0, 1, "R3 random down");
      else if (op == 7) pulse(1, 1, "R6 random both");
      else if (op == 8) do_load($urandom_range(0, 15));
      else do_clear($urandom_range(0, 1) == 1);
    end

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule